// File: doc/BRIEF.md
# Presettable Up/Down Binary Counter

This block is a small binary counter that steps one count per rising clock edge, upward or downward as a direction input selects. A level-sensitive preset copies a data word onto the count output at once. It can be held still by an active-low enable and cleared at any time by an asynchronous clear. The count wraps around in both directions.

An active-low terminal flag marks the last state before a wrap in the current direction. The flag is decoded combinationally from the count, the direction and the enable. Because of this, several stages can be chained: the flag of one stage feeds the enable of the next. A stage whose enable is off never raises its flag, so a chain only carries a step when every lower stage sits at its end value.

Top module: `udc_counter`

## Requirements
- R1: While `clear` is high, `count` is all zeros at once, with no clock edge needed and whatever the other inputs are, `load` included.
- R2: While `load` is high and `clear` is low, `count` equals `load_val` at once, with no clock edge needed, whatever `run_n` and `dir_up` are.
- R3: The value on `load_val` at the last rising edge during a load is kept on `count` after `load` falls.
- R4: With `load` and `run_n` low and `dir_up` high (1 = up), each rising edge adds one to `count`.
- R5: With `load` and `run_n` low and `dir_up` low (0 = down), each rising edge subtracts one from `count`.
- R6: The count wraps modulo 2^WIDTH: all ones steps to zero going up, and zero steps to all ones going down.
- R7: With `run_n` high and `load` and `clear` low, `count` keeps its value across rising edges.
- R8: `term_n` is low when `run_n` is low, `dir_up` is high and `count` is all ones.
- R9: `term_n` is low when `run_n` is low, `dir_up` is low and `count` is all zeros; in every case not covered by R8 or R9, `term_n` is high.
- R10: `term_n` stays high whenever `run_n` is high, whatever the count.
- R11: A change on `run_n` or `dir_up` reaches `term_n` with no clock edge.
- R12: Outside clear and load, `count` changes only at a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge |
| clear | input | 1 | Asynchronous clear to zero, active high |
| load | input | 1 | Level preset from `load_val`, active high |
| load_val | input | WIDTH | Preset data word |
| dir_up | input | 1 | Count direction, 1 = up, 0 = down |
| run_n | input | 1 | Count enable, active low |
| count | output | WIDTH | Current count |
| term_n | output | 1 | Terminal flag, active low |

## Verification
The bench aims at both wrap points. A design that mishandled modulo arithmetic there would saturate or jump, and a terminal decode that ignored direction would flag all ones while counting down. It also probes `term_n` between clock edges while it toggles enable and direction. A registered flag would lag by one cycle, and a flag not gated by the enable would go low on a held stage and corrupt a chain. Finally, it checks that clear beats a simultaneous load and that a load shows on the output before any edge. A clocked preset would show the old count for a cycle, and a wrong priority would let the preset leak through the clear.

// File: rtl/udc_pkg.sv
`timescale 1ns/1ps
package udc_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_LOAD = 2'd1,
    MODE_UP   = 2'd2,
    MODE_DOWN = 2'd3
  } udc_mode_e;
endpackage

// File: rtl/udc_mode_sel.sv
`timescale 1ns/1ps
module udc_mode_sel
  import udc_pkg::*;
(
  input  logic      load,
  input  logic      run_n,
  input  logic      dir_up,
  output udc_mode_e mode
);
  // priority below clear: load, then hold, then count
  always_comb begin
    if (load)       mode = MODE_LOAD;
    else if (run_n) mode = MODE_HOLD;
    else if (dir_up) mode = MODE_UP;
    else            mode = MODE_DOWN;
  end
endmodule

// File: rtl/udc_step.sv
`timescale 1ns/1ps
module udc_step
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  udc_mode_e        mode,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] nxt,
  output logic             upd
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    upd = 1'b1;
    unique case (mode)
      MODE_LOAD: nxt = preset;
      MODE_UP:   nxt = cur + ONE;
      MODE_DOWN: nxt = cur - ONE;
      default: begin
        nxt = cur;
        upd = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/udc_term.sv
`timescale 1ns/1ps
module udc_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] value,
  input  logic             dir_up,
  input  logic             run_n,
  output logic             term_n
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] BOT = '0;

  logic at_end;

  always_comb begin
    at_end = dir_up ? (value == TOP) : (value == BOT);
    term_n = ~(at_end & ~run_n);
  end
endmodule

// File: rtl/udc_counter.sv
`timescale 1ns/1ps
module udc_counter
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             dir_up,
  input  logic             run_n,
  output logic [WIDTH-1:0] count,
  output logic             term_n
);
  udc_mode_e        mode;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;

  udc_mode_sel u_mode (
    .load   (load),
    .run_n  (run_n),
    .dir_up (dir_up),
    .mode   (mode)
  );

  udc_step #(.WIDTH(WIDTH)) u_step (
    .mode   (mode),
    .cur    (cnt_q),
    .preset (load_val),
    .nxt    (cnt_d),
    .upd    (cnt_en)
  );

  // state register with written-out clock enable
  always_ff @(posedge clk or posedge clear) begin
    if (clear)       cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // clear and preset bypass the register so they act between edges
  always_comb begin
    if (clear)     count = '0;
    else if (load) count = load_val;
    else           count = cnt_q;
  end

  udc_term #(.WIDTH(WIDTH)) u_term (
    .value  (count),
    .dir_up (dir_up),
    .run_n  (run_n),
    .term_n (term_n)
  );
endmodule

// File: rtl/udc_counter_chk.sv
`timescale 1ns/1ps
module udc_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clear,
  input logic             load,
  input logic [WIDTH-1:0] load_val,
  input logic             dir_up,
  input logic             run_n,
  input logic [WIDTH-1:0] count,
  input logic             term_n
);
  AST_CLEAR_ZERO: assert property (@(posedge clk) clear |-> count == '0); // R1
  AST_LOAD_BYPASS: assert property (@(posedge clk) disable iff (clear) load |-> count == load_val); // R2
  AST_UP_STEP: assert property (@(posedge clk) disable iff (clear)
    (!load && !run_n && dir_up) |=> (load || count == WIDTH'($past(count) + 1'b1))); // R4
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (clear)
    (!load && !run_n && !dir_up) |=> (load || count == WIDTH'($past(count) - 1'b1))); // R5
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (clear)
    (!load && run_n) |=> (load || $stable(count))); // R7
  AST_TERM_UP: assert property (@(posedge clk) disable iff (clear)
    (!run_n && dir_up && count == {WIDTH{1'b1}}) |-> !term_n); // R8
  AST_TERM_IDLE: assert property (@(posedge clk) disable iff (clear) run_n |-> term_n); // R10
endmodule

bind udc_counter udc_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .clear    (clear),
  .load     (load),
  .load_val (load_val),
  .dir_up   (dir_up),
  .run_n    (run_n),
  .count    (count),
  .term_n   (term_n)
);

// File: tb/tb_udc_counter.sv
`timescale 1ns/1ps
module tb_udc_counter;
  localparam int W = 4;

  typedef struct packed {
    logic         ld;
    logic [W-1:0] val;
    logic         up;
    logic         rn;
    logic [W-1:0] exp;
    logic         exp_t;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'hE, 1'b1, 1'b0, 4'hE, 1'b1},  // load beats count
    '{1'b0, 4'h0, 1'b1, 1'b0, 4'hF, 1'b0},  // up to top, flag
    '{1'b0, 4'h0, 1'b1, 1'b0, 4'h0, 1'b1},  // up wrap
    '{1'b0, 4'h0, 1'b0, 1'b0, 4'hF, 1'b1},  // down wrap
    '{1'b0, 4'h0, 1'b0, 1'b0, 4'hE, 1'b1},
    '{1'b0, 4'h0, 1'b0, 1'b1, 4'hE, 1'b1},  // hold
    '{1'b1, 4'h1, 1'b0, 1'b0, 4'h1, 1'b1},
    '{1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0},  // down to zero, flag
    '{1'b0, 4'h0, 1'b0, 1'b1, 4'h0, 1'b1},  // hold at zero, no flag
    '{1'b0, 4'h0, 1'b1, 1'b0, 4'h1, 1'b1},
    '{1'b1, 4'h5, 1'b1, 1'b1, 4'h5, 1'b1},  // load beats hold
    '{1'b0, 4'h0, 1'b1, 1'b0, 4'h6, 1'b1}
  };

  logic         clk = 1'b0;
  logic         clear, load, dir_up, run_n;
  logic [W-1:0] load_val;
  logic [W-1:0] count;
  logic         term_n;
  int           n_chk = 0;
  int           n_err = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  udc_counter #(.WIDTH(W)) dut (
    .clk(clk), .clear(clear), .load(load), .load_val(load_val),
    .dir_up(dir_up), .run_n(run_n), .count(count), .term_n(term_n)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] prev;
    string tag;
    clear = 1'b1; load = 1'b0; load_val = '0; dir_up = 1'b1; run_n = 1'b1;
    #1;
    chk("R1 reset count", count, '0);
    chk("R10 reset flag", W'(term_n), W'(1));
    @(negedge clk); @(negedge clk);
    clear = 1'b0;
    prev = '0;

    // table walk: apply at falling edge, check at the next falling edge
    for (int i = 0; i < NV; i++) begin
      load = VECS[i].ld; load_val = VECS[i].val;
      dir_up = VECS[i].up; run_n = VECS[i].rn;
      @(negedge clk);
      if (VECS[i].ld) tag = "R2";
      else if (VECS[i].rn) tag = "R7";
      else if ((VECS[i].up && prev == 4'hF) || (!VECS[i].up && prev == 4'h0)) tag = "R6";
      else if (VECS[i].up) tag = "R4";
      else tag = "R5";
      chk($sformatf("%s count vec%0d", tag, i), count, VECS[i].exp);
      chk($sformatf("%s flag vec%0d", VECS[i].rn ? "R10" : (VECS[i].up ? "R8" : "R9"), i),
          W'(term_n), W'(VECS[i].exp_t));
      prev = VECS[i].exp;
    end

    // R1: clear between edges, then over a load
    load = 1'b0; run_n = 1'b1;
    #0.5 clear = 1'b1;
    #0.5 chk("R1 async clear", count, '0);
    load = 1'b1; load_val = 4'h9;
    #0.3 chk("R1 clear over load", count, '0);
    clear = 1'b0;
    #0.3 chk("R2 bypass after clear", count, 4'h9);
    @(negedge clk);
    load_val = 4'h3;
    #0.5 chk("R2 bypass no edge", count, 4'h3);
    @(negedge clk);
    load = 1'b0;
    #0.5 chk("R3 retained after load", count, 4'h3);

    // R11: flag follows enable and direction between edges
    load = 1'b1; load_val = 4'hF;
    @(negedge clk);
    load = 1'b0;
    #0.2 chk("R10 flag off while held", W'(term_n), W'(1));
    run_n = 1'b0; dir_up = 1'b1;
    #0.5 chk("R11 R8 flag on enable", W'(term_n), W'(0));
    dir_up = 1'b0;
    #0.5 chk("R11 flag off on direction", W'(term_n), W'(1));
    run_n = 1'b1;
    @(negedge clk);

    // R12: no change before the edge, then one step down
    run_n = 1'b0; dir_up = 1'b0;
    #1.5 chk("R12 stable before edge", count, 4'hF);
    @(negedge clk);
    chk("R5 step after edge", count, 4'hE);
    run_n = 1'b1;
    @(negedge clk);
    chk("R7 hold final", count, 4'hE);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule